// File: doc/BRIEF.md
# Hybrid Virtual/Physical Cache Controller

This block is a small direct-mapped data cache controller whose first tag lookup uses the CPU's virtual address. An external translation buffer converts the same address at the same time. The translation result includes a shared-page flag. When the flag is clear, the virtual lookup is the final answer and translation adds no latency. When the flag is set, the page may be reachable through more than one virtual address. The virtual result is then discarded and a second lookup is made with the translated physical address, so two aliases of one physical word always resolve to a single cache line.

Each line stores a kind bit next to its tag. Kind 0 marks a virtual tag and kind 1 marks a physical tag. A lookup matches only lines whose kind equals the kind of address being compared. Read misses refill the whole line from memory over a single-beat request/acknowledge port. The line is tagged virtually for a private page and physically for a shared page. Writes go through to memory. Only one request is in flight at a time.

All addresses are word addresses. The low `log2(LINE_WORDS)` bits select the word in a line. The next `log2(LINES)` bits select the line. The remaining bits form the tag. The word offset is untranslated, so the low offset bits of the virtual and physical addresses are equal.

Top module: `hybrid_cache_ctl`

## Requirements
- R1: After reset, `reqReady` is 1, `respDone` is 0, `memReq` is 0 and every line is invalid, so the first read reports `respHit`=0.
- R2: With `tlbShared`=0, the virtual lookup is final. A read hit raises `respDone` in the second cycle after the accepting edge, with `respHit`=1 and the cached word on `respRdata`.
- R3: With `tlbShared`=1, the result comes only from the physical lookup. A read hit raises `respDone` in the third cycle after the accepting edge, one cycle later than a private-page hit.
- R4: A lookup matches only a valid line whose kind bit equals the lookup kind (0 for virtual, 1 for physical) and whose tag equals the address tag. A virtual match on a shared-page access is discarded.
- R5: When `tlbHit`=0, the access ends with `respDone` in the second cycle after acceptance, with `respTrap`=1 and `respHit`=0, and no memory request is made.
- R6: A read miss issues `LINE_WORDS` read requests at the physical line base in ascending word order. It answers with `respHit`=0 and the requested word. The line is tagged with kind 1 and the physical tag if the page is shared, otherwise with kind 0 and the virtual tag.
- R7: A write hit updates the cached word, makes exactly one memory write of `reqWdata` at the physical address, and reports `respHit`=1.
- R8: A write miss makes one memory write, reports `respHit`=0 and allocates no line.
- R9: `reqReady` is 0 from the cycle after acceptance through the `respDone` cycle. A request presented meanwhile is ignored.
- R10: Two virtual addresses on a shared page that map to the same physical word hit the same physically tagged line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | CPU request present |
| reqReady | output | 1 | Controller idle, accepts a request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqVa | input | VA_W | Virtual word address |
| reqWdata | input | DATA_W | Write data |
| tlbHit | input | 1 | Translation found; sampled with the request |
| tlbShared | input | 1 | Page is shared; sampled with the request |
| tlbPa | input | PA_W | Translated word address; sampled with the request |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | PA_W | Memory word address |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data, valid with memAck |
| memAck | input | 1 | Memory completes the current beat |
| respDone | output | 1 | One-cycle completion pulse |
| respHit | output | 1 | Final lookup hit, valid with respDone |
| respTrap | output | 1 | Translation missed, valid with respDone |
| respRdata | output | DATA_W | Read data, valid with respDone on reads |

## Verification
The delicate case is a virtual tag match that occurs in the same cycle that the shared flag orders a second, physical lookup. The provisional hit must be thrown away. The bench provokes this by filling a line through a private page and then reading the same virtual address with the shared flag set and a physical address whose line is absent. It judges the result by a reported miss, a full refill burst and the later behaviour of both addresses. A second collision, a request held on the inputs while the completion pulse is high, is driven on purpose. Its effect is judged by the absence of any extra completion and by later results matching the reference model.

// File: rtl/hc_pkg.sv
package hc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_VLOOK = 3'd1,
    ST_PLOOK = 3'd2,
    ST_FILL  = 3'd3,
    ST_WMEM  = 3'd4,
    ST_RESP  = 3'd5
  } hcState_t;

  typedef struct packed {
    logic latch;       // capture request and translation
    logic usePhys;     // index/tag from the physical address, kind 1
    logic hitCapture;  // load read data from the hit line
    logic hitWrite;    // update the hit word with write data
    logic fillWrite;   // store one refill beat
    logic fillTag;     // set valid, kind and tag of the refilled line
    logic beatClr;     // restart the refill beat counter
    logic beatInc;     // advance the refill beat counter
  } hcStrobe_t;

endpackage

// File: rtl/hc_datapath.sv
module hc_datapath
  import hc_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int DATA_W     = 32,
  parameter int LINES      = 16,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  hcStrobe_t         stb,
  input  logic [VA_W-1:0]   reqVa,
  input  logic [PA_W-1:0]   reqPa,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              tlbHit,
  input  logic              tlbShared,
  input  logic [DATA_W-1:0] memRdata,
  output logic              lookMatch,
  output logic              sharedQ,
  output logic              tlbHitQ,
  output logic              writeQ,
  output logic              lastBeat,
  output logic [PA_W-1:0]   memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int VTAG_W = VA_W - IDX_W - OFF_W;
  localparam int PTAG_W = PA_W - IDX_W - OFF_W;
  localparam int TAG_W  = (VTAG_W > PTAG_W) ? VTAG_W : PTAG_W;

  logic [VA_W-1:0]   vaQ;
  logic [PA_W-1:0]   paQ;
  logic [DATA_W-1:0] wdataQ;
  logic [OFF_W-1:0]  beatQ;

  logic [LINES-1:0]  validArr;
  logic [LINES-1:0]  kindArr;
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [DATA_W-1:0] dataArr [LINES][LINE_WORDS];

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [OFF_W-1:0]  off;

  // request capture, taken in the accepting cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ     <= '0;
      paQ     <= '0;
      wdataQ  <= '0;
      sharedQ <= 1'b0;
      tlbHitQ <= 1'b0;
      writeQ  <= 1'b0;
    end else if (stb.latch) begin
      vaQ     <= reqVa;
      paQ     <= reqPa;
      wdataQ  <= reqWdata;
      sharedQ <= tlbShared;
      tlbHitQ <= tlbHit;
      writeQ  <= reqWrite;
    end
  end

  // lookup address selection: same bit positions for both kinds
  always_comb begin
    off = vaQ[OFF_W-1:0];
    if (stb.usePhys) begin
      idx = paQ[OFF_W +: IDX_W];
      tag = TAG_W'(paQ[PA_W-1:OFF_W+IDX_W]);
    end else begin
      idx = vaQ[OFF_W +: IDX_W];
      tag = TAG_W'(vaQ[VA_W-1:OFF_W+IDX_W]);
    end
  end

  assign lookMatch = validArr[idx] && (kindArr[idx] == stb.usePhys) &&
                     (tagArr[idx] == tag);

  always_ff @(posedge clk) begin
    if (!rstN) validArr <= '0;
    else if (stb.fillTag) validArr[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (stb.fillTag) begin
      kindArr[idx] <= stb.usePhys;
      tagArr[idx]  <= tag;
    end
    if (stb.fillWrite) dataArr[idx][beatQ] <= memRdata;
    if (stb.hitWrite)  dataArr[idx][off]   <= wdataQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) beatQ <= '0;
    else if (stb.beatClr) beatQ <= '0;
    else if (stb.beatInc) beatQ <= beatQ + 1'b1;
  end

  assign lastBeat = (beatQ == OFF_W'(LINE_WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) rdata <= '0;
    else if (stb.hitCapture) rdata <= dataArr[idx][off];
    else if (stb.fillWrite && (beatQ == off)) rdata <= memRdata;
  end

  assign memAddr  = writeQ ? paQ : {paQ[PA_W-1:OFF_W], beatQ};
  assign memWdata = wdataQ;

endmodule

// File: rtl/hc_control.sv
module hc_control
  import hc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      lookMatch,
  input  logic      sharedQ,
  input  logic      tlbHitQ,
  input  logic      writeQ,
  input  logic      lastBeat,
  input  logic      memAck,
  output hcStrobe_t stb,
  output logic      reqReady,
  output logic      memReq,
  output logic      memWe,
  output logic      respDone,
  output logic      respHit,
  output logic      respTrap
);

  hcState_t state, nxt;
  logic hitQ, trapQ;
  logic setHit, setTrap, clrFlags, finalStep;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      hitQ  <= 1'b0;
      trapQ <= 1'b0;
    end else begin
      state <= nxt;
      if (clrFlags) begin
        hitQ  <= 1'b0;
        trapQ <= 1'b0;
      end else begin
        if (setHit)  hitQ  <= 1'b1;
        if (setTrap) trapQ <= 1'b1;
      end
    end
  end

  // a lookup is final in the physical stage, or in the virtual stage
  // of a translated private page
  assign finalStep = (state == ST_PLOOK) ||
                     ((state == ST_VLOOK) && tlbHitQ && !sharedQ);

  always_comb begin
    nxt      = state;
    stb      = '0;
    reqReady = 1'b0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    respDone = 1'b0;
    setHit   = 1'b0;
    setTrap  = 1'b0;
    clrFlags = 1'b0;
    stb.usePhys = (state == ST_PLOOK) || ((state == ST_FILL) && sharedQ);

    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.latch = 1'b1;
          clrFlags  = 1'b1;
          nxt       = ST_VLOOK;
        end
      end
      ST_VLOOK: begin
        if (!tlbHitQ) begin
          setTrap = 1'b1;
          nxt     = ST_RESP;
        end else if (sharedQ) begin
          nxt = ST_PLOOK;
        end
      end
      ST_FILL: begin
        memReq = 1'b1;
        if (memAck) begin
          stb.fillWrite = 1'b1;
          if (lastBeat) begin
            stb.fillTag = 1'b1;
            nxt         = ST_RESP;
          end else begin
            stb.beatInc = 1'b1;
          end
        end
      end
      ST_WMEM: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) nxt = ST_RESP;
      end
      ST_RESP: begin
        respDone = 1'b1;
        nxt      = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase

    if (finalStep) begin
      if (writeQ) begin
        stb.hitWrite = lookMatch;
        setHit       = lookMatch;
        nxt          = ST_WMEM;
      end else if (lookMatch) begin
        stb.hitCapture = 1'b1;
        setHit         = 1'b1;
        nxt            = ST_RESP;
      end else begin
        stb.beatClr = 1'b1;
        nxt         = ST_FILL;
      end
    end
  end

  assign respHit  = hitQ;
  assign respTrap = trapQ;

endmodule

// File: rtl/hybrid_cache_ctl.sv
module hybrid_cache_ctl
  import hc_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int DATA_W     = 32,
  parameter int LINES      = 16,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [VA_W-1:0]   reqVa,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              tlbHit,
  input  logic              tlbShared,
  input  logic [PA_W-1:0]   tlbPa,
  output logic              memReq,
  output logic              memWe,
  output logic [PA_W-1:0]   memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  output logic              respDone,
  output logic              respHit,
  output logic              respTrap,
  output logic [DATA_W-1:0] respRdata
);

  hcStrobe_t stb;
  logic lookMatch, sharedQ, tlbHitQ, writeQ, lastBeat;

  hc_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .lookMatch (lookMatch),
    .sharedQ   (sharedQ),
    .tlbHitQ   (tlbHitQ),
    .writeQ    (writeQ),
    .lastBeat  (lastBeat),
    .memAck    (memAck),
    .stb       (stb),
    .reqReady  (reqReady),
    .memReq    (memReq),
    .memWe     (memWe),
    .respDone  (respDone),
    .respHit   (respHit),
    .respTrap  (respTrap)
  );

  hc_datapath #(
    .VA_W       (VA_W),
    .PA_W       (PA_W),
    .DATA_W     (DATA_W),
    .LINES      (LINES),
    .LINE_WORDS (LINE_WORDS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqVa     (reqVa),
    .reqPa     (tlbPa),
    .reqWrite  (reqWrite),
    .reqWdata  (reqWdata),
    .tlbHit    (tlbHit),
    .tlbShared (tlbShared),
    .memRdata  (memRdata),
    .lookMatch (lookMatch),
    .sharedQ   (sharedQ),
    .tlbHitQ   (tlbHitQ),
    .writeQ    (writeQ),
    .lastBeat  (lastBeat),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .rdata     (respRdata)
  );

endmodule

// File: rtl/hc_checker.sv
module hc_checker #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic            tlbHit,
  input logic            memReq,
  input logic            memWe,
  input logic [PA_W-1:0] memAddr,
  input logic            memAck,
  input logic            respDone,
  input logic            respHit,
  input logic            respTrap
);

  p_idle_no_mem_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReq);

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    respDone |=> !respDone);

  p_trap_path_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !tlbHit) |=> !memReq ##1 (respDone && respTrap && !respHit));

  p_beat_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  p_done_not_ready_r9: assert property (@(posedge clk) disable iff (!rstN)
    respDone |-> !reqReady);

endmodule

bind hybrid_cache_ctl hc_checker #(.PA_W(PA_W)) u_chk (.*);

// File: tb/hybrid_cache_ctl_test.sv
module hybrid_cache_ctl_test;

  localparam int VA_W = 32, PA_W = 32, DATA_W = 32, LINES = 16, LINE_WORDS = 4;
  localparam int OFF_W = 2, IDX_W = 4, MEM_N = 4096;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, tlbHit = 1'b0, tlbShared = 1'b0;
  logic [VA_W-1:0] reqVa = '0;
  logic [PA_W-1:0] tlbPa = '0;
  logic [DATA_W-1:0] reqWdata = '0, memRdata = '0, memWdata, respRdata;
  logic reqReady, memReq, memWe, respDone, respHit, respTrap, memAck = 1'b0;
  logic [PA_W-1:0] memAddr;

  always #5 clk = ~clk;

  hybrid_cache_ctl uut (.*);

  logic [31:0] mem [MEM_N];
  logic [31:0] refMem [MEM_N];
  int unsigned rdCnt = 0, wrCnt = 0;
  logic [31:0] rdLog [8];
  int nChecks = 0, nFail = 0;

  bit mValid [LINES];
  bit mKind [LINES];
  int unsigned mTag [LINES];
  logic [31:0] mData [LINES][LINE_WORDS];

  function automatic logic [31:0] seedVal(int unsigned a);
    return (a * 32'h9E3779B1) ^ 32'hC0DE0000;
  endfunction

  // memory responder: one acknowledge per held request, one cycle later
  always @(posedge clk) begin
    memAck <= memReq && !memAck;
    if (memReq && !memAck) memRdata <= mem[memAddr[11:0]];
    if (memReq && memAck) begin
      if (memWe) begin
        mem[memAddr[11:0]] <= memWdata;
        wrCnt <= wrCnt + 1;
      end else begin
        rdLog[rdCnt % 8] <= memAddr;
        rdCnt <= rdCnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference model of one access; updates the model state
  task automatic model(input logic [31:0] va, input logic [31:0] pa,
                       input bit sh, input bit th, input bit we, input logic [31:0] wd,
                       output bit eHit, output bit eTrap, output logic [31:0] eData,
                       output int eRd, output int eWr);
    int unsigned key, i, tg, off;
    eHit = 0; eTrap = 0; eData = '0; eRd = 0; eWr = 0;
    if (!th) begin eTrap = 1; return; end
    key = sh ? pa : va;
    i = (key >> OFF_W) % LINES;
    tg = key >> (OFF_W + IDX_W);
    off = va % LINE_WORDS;
    eHit = mValid[i] && (mKind[i] == sh) && (mTag[i] == tg);
    if (we) begin
      eWr = 1;
      refMem[pa % MEM_N] = wd;
      if (eHit) mData[i][off] = wd;
    end else if (eHit) begin
      eData = mData[i][off];
    end else begin
      eRd = LINE_WORDS;
      for (int w = 0; w < LINE_WORDS; w++)
        mData[i][w] = refMem[((pa >> OFF_W) << OFF_W) + w];
      mValid[i] = 1; mKind[i] = sh; mTag[i] = tg;
      eData = refMem[pa % MEM_N];
    end
  endtask

  task automatic access(input logic [31:0] va, input logic [31:0] pa, input bit sh,
                        input bit th, input bit we, input logic [31:0] wd,
                        input string req, input bit hold);
    bit eHit, eTrap;
    logic [31:0] eData;
    int eRd, eWr, lat, expLat;
    int unsigned rd0, wr0;
    model(va, pa, sh, th, we, wd, eHit, eTrap, eData, eRd, eWr);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    rd0 = rdCnt; wr0 = wrCnt;
    reqValid = 1; reqVa = va; tlbPa = pa; tlbShared = sh; tlbHit = th;
    reqWrite = we; reqWdata = wd;
    @(negedge clk);
    check(reqReady == 0, "R9", "ready after accept", 32'(reqReady), 0);
    // scramble the sampled inputs; hold a competing request if asked
    reqValid = hold; reqVa = $urandom; tlbPa = $urandom; tlbShared = ~sh;
    tlbHit = ~th; reqWrite = ~we; reqWdata = $urandom;
    lat = 1;
    while (!respDone) begin @(negedge clk); lat++; end
    reqValid = 0;
    check(respTrap == eTrap, eTrap ? "R5" : req, "trap", 32'(respTrap), 32'(eTrap));
    check(respHit == eHit, req, "hit", 32'(respHit), 32'(eHit));
    if (eTrap || (!we && eHit)) begin
      expLat = (th && sh) ? 3 : 2;
      check(lat == expLat, eTrap ? "R5" : (sh ? "R3" : "R2"), "latency", lat, expLat);
    end
    if (!we && !eTrap)
      check(respRdata == eData, req, "read data", respRdata, eData);
    check((rdCnt - rd0) == eRd, eTrap ? "R5" : "R6", "read beats", rdCnt - rd0, eRd);
    for (int k = 0; k < eRd; k++)
      check(rdLog[(rd0 + k) % 8] == (((pa >> OFF_W) << OFF_W) + k), "R6", "refill order",
            rdLog[(rd0 + k) % 8], ((pa >> OFF_W) << OFF_W) + k);
    check((wrCnt - wr0) == eWr, we ? (eHit ? "R7" : "R8") : "R5", "write beats",
          wrCnt - wr0, eWr);
    if (we && th)
      check(mem[pa % MEM_N] == wd, eHit ? "R7" : "R8", "memory word", mem[pa % MEM_N], wd);
    if (hold) begin
      @(negedge clk);
      @(negedge clk);
      check(respDone == 0 && reqReady == 1, "R9", "held request ignored",
            {respDone, reqReady}, 32'b01);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] va, pa;
    bit sh, th, we;
    string lbl;
    void'($urandom(32'd1234));
    for (int a = 0; a < MEM_N; a++) begin mem[a] = seedVal(a); refMem[a] = seedVal(a); end
    for (int i = 0; i < LINES; i++) mValid[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(reqReady == 1, "R1", "ready after reset", 32'(reqReady), 1);
    check(respDone == 0, "R1", "done after reset", 32'(respDone), 0);
    check(memReq == 0, "R1", "memReq after reset", 32'(memReq), 0);

    access(32'h104, 32'h844, 0, 1, 0, 0, "R1", 0);          // empty cache misses
    access(32'h104, 32'h844, 0, 1, 0, 0, "R2", 0);          // private hit
    access(32'h104, 32'h844, 1, 1, 0, 0, "R4", 0);          // virtual match discarded
    access(32'h104, 32'h844, 0, 1, 0, 0, "R4", 0);          // line now physical
    access(32'h208, 32'h208, 0, 1, 0, 0, "R6", 0);
    access(32'h208, 32'h208, 1, 1, 0, 0, "R4", 0);          // same bits, kind differs
    access(32'h208, 32'h208, 1, 1, 0, 0, "R3", 0);          // shared hit
    access(32'h30c, 32'h208, 1, 1, 0, 0, "R10", 0);         // alias hits same line
    access(32'h30c, 32'h208, 1, 1, 1, 32'hDEADBEEF, "R7", 0);
    access(32'h208, 32'h208, 1, 1, 0, 0, "R7", 0);
    access(32'h7f0, 32'h9f0, 0, 1, 1, 32'h0BADF00D, "R8", 0);
    access(32'h7f0, 32'h9f0, 0, 1, 0, 0, "R8", 0);          // no allocation
    access(32'h104, 32'h844, 0, 0, 0, 0, "R5", 0);
    access(32'h104, 32'h844, 0, 1, 0, 0, "R9", 1);

    for (int n = 0; n < 600; n++) begin
      va = $urandom % 1024;
      pa = (($urandom % 256) << OFF_W) | (va % LINE_WORDS);
      sh = ($urandom % 10) < 3;
      th = ($urandom % 20) != 0;
      we = ($urandom % 10) < 3;
      lbl = !th ? "R5" : we ? "R7/R8" : sh ? "R3/R6" : "R2/R6";
      access(va, pa, sh, th, we, $urandom, lbl, ($urandom % 16) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule